// File: doc/BRIEF.md
# Configuration and Run Mode Supervisor

This block sequences board bring-up for an FPGA that loads its own image from external flash. Right after reset it holds the FPGA program line low so that the FPGA reconfigures. While it does so, it samples a debounced update button. If the button is not pressed, it checks that the program line comes back high through its pull-up. It then waits a bounded time for the configuration-done line. Based on these results it settles in one of three modes: a transparent serial bridge (run), flash update, or bootloader.

A single activity LED shows where the sequence stands. It blinks slowly for a missing pull-up, shows a burst pattern while it waits for DONE, blinks fast for a DONE timeout, and stays on steadily in the update and bootloader modes. In run mode the LED stays dark except for stretched pulses on serial traffic. A DONE timeout does not leave the board stuck: after the fast-blink display the block falls back to update mode on its own. The update engine can ask for a restart on the run path, or for a move to the bootloader.

Top module: `cfg_supervisor`

## Requirements
- R1: For SAMPLE_CYC cycles after reset release, prog_b_low_o is 1, mode_o is 0 (start), bridge_en_o is 0 and led_o is 0.
- R2: If the debounced update button is high at the end of the sampling window, mode_o becomes 2 (update), led_o is steadily 1 and bridge_en_o is 0.
- R3: If the synchronised program line does not read high within PCHK_CYC cycles after the low drive is released, led_o toggles every SLOW_HALF cycles indefinitely and mode_o stays 0.
- R4: While waiting for DONE, led_o is high when both the slow and the fast blink phases are high, which is exactly one quarter of any 2*SLOW_HALF window when SLOW_HALF is a multiple of 2*FAST_HALF.
- R5: If DONE stays low for DONE_TO_CYC cycles, led_o toggles every FAST_HALF cycles for FAULT_CYC cycles, and mode_o then becomes 2 with led_o steadily 1.
- R6: When the synchronised DONE goes high during the wait, mode_o becomes 1 (run), bridge_en_o goes to 1 and led_o is 0 without serial activity.
- R7: In run mode, a one-cycle pulse on rx_act_i or tx_act_i makes led_o high for STRETCH_CYC cycles, and a new pulse restarts the stretch.
- R8: upd_reset_i in update mode restarts the sequence with prog_b_low_o at 1, ignores the button, and reaches run mode once DONE rises.
- R9: upd_exit_i in update mode moves mode_o to 3 (bootloader). Mode 3 holds with led_o at 1 until reset.
- R10: upd_reset_i and upd_exit_i have no effect outside update mode.
- R11: The button, program and DONE inputs pass through two flip-flops. A button level that lasts for fewer than DEB_CYC cycles is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| upd_btn_i | input | 1 | Update button, high when pressed |
| prog_b_i | input | 1 | Sensed FPGA program line |
| done_i | input | 1 | FPGA configuration-done line |
| rx_act_i | input | 1 | Receive activity strobe |
| tx_act_i | input | 1 | Transmit activity strobe |
| upd_reset_i | input | 1 | Restart request from the update engine |
| upd_exit_i | input | 1 | Bootloader request from the update engine |
| prog_b_low_o | output | 1 | Drive the program line low |
| bridge_en_o | output | 1 | Serial bridge enable |
| led_o | output | 1 | Activity LED |
| mode_o | output | 2 | 0 start, 1 run, 2 update, 3 bootloader |

## Verification
Inputs go through two synchroniser flops, so a rise on DONE shows up in mode_o and bridge_en_o three clock edges later. The button needs DEB_CYC further cycles of debounce before it counts. Window and timeout transitions land an exact number of edges after their state is entered. The bench samples mode checks a few cycles inside each side of such a boundary. It measures blink half-periods and stretch lengths directly, counting the falling edges between LED toggles, so these checks are exact and do not depend on the entry cycle. The command checks sample one edge after the request, or after a settling gap when a command must have no effect.

// File: rtl/cfg_sup_pkg.sv
package cfg_sup_pkg;
  typedef enum logic [2:0] {
    ST_SAMPLE, ST_PCHK, ST_PFAULT, ST_WDONE, ST_DFAULT, ST_RUN, ST_UPD, ST_BOOT
  } sup_state_e;

  typedef enum logic [1:0] {
    MODE_START  = 2'd0,
    MODE_RUN    = 2'd1,
    MODE_UPDATE = 2'd2,
    MODE_BOOT   = 2'd3
  } sup_mode_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cfg_sup_sync.sv
module cfg_sup_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/cfg_sup_debounce.sv
module cfg_sup_debounce #(
  parameter int unsigned CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q_o   <= 1'b0;
    end else if (d_i == q_o) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(CYC - 1)) begin
      cnt_q <= '0;
      q_o   <= d_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_sup_blink.sv
module cfg_sup_blink #(
  parameter int unsigned HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic ph_o
);
  localparam int CW = $clog2(HALF + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_o  <= 1'b1;
    end else if (clr_i) begin
      cnt_q <= '0;
      ph_o  <= 1'b1;
    end else if (cnt_q == CW'(HALF - 1)) begin
      cnt_q <= '0;
      ph_o  <= ~ph_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_sup_stretch.sv
module cfg_sup_stretch #(
  parameter int unsigned LEN = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic led_o
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (act_i)         cnt_q <= CW'(LEN);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign led_o = (cnt_q != '0);
endmodule

// File: rtl/cfg_supervisor.sv
module cfg_supervisor
  import cfg_sup_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 48_000_000,
  parameter int unsigned DEB_CYC     = CLK_HZ / 100,
  parameter int unsigned SAMPLE_CYC  = DEB_CYC + 4,
  parameter int unsigned PCHK_CYC    = CLK_HZ / 1000,
  parameter int unsigned DONE_TO_CYC = 3 * CLK_HZ,
  parameter int unsigned FAULT_CYC   = 2 * CLK_HZ,
  parameter int unsigned SLOW_HALF   = CLK_HZ / 2,
  parameter int unsigned FAST_HALF   = CLK_HZ / 16,
  parameter int unsigned STRETCH_CYC = CLK_HZ / 50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       upd_btn_i,
  input  logic       prog_b_i,
  input  logic       done_i,
  input  logic       rx_act_i,
  input  logic       tx_act_i,
  input  logic       upd_reset_i,
  input  logic       upd_exit_i,
  output logic       prog_b_low_o,
  output logic       bridge_en_o,
  output logic       led_o,
  output logic [1:0] mode_o
);
  localparam int unsigned TMAX = max2(max2(SAMPLE_CYC, PCHK_CYC), max2(DONE_TO_CYC, FAULT_CYC));
  localparam int TW = $clog2(TMAX + 1);

  logic [2:0] sync_q;
  logic       btn_q, prog_s, done_s;
  logic       slow_ph, fast_ph, act_led;
  logic       restart_q, chg;
  logic [TW-1:0] tmr_q;
  sup_state_e state_q, nxt;

  cfg_sup_sync #(.W(3)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({upd_btn_i, prog_b_i, done_i}),
    .q_o (sync_q)
  );
  assign prog_s = sync_q[1];
  assign done_s = sync_q[0];

  cfg_sup_debounce #(.CYC(DEB_CYC)) u_deb (
    .clk_i, .rst_ni, .d_i(sync_q[2]), .q_o(btn_q)
  );

  cfg_sup_blink #(.HALF(SLOW_HALF)) u_slow (
    .clk_i, .rst_ni, .clr_i(chg), .ph_o(slow_ph)
  );
  cfg_sup_blink #(.HALF(FAST_HALF)) u_fast (
    .clk_i, .rst_ni, .clr_i(chg), .ph_o(fast_ph)
  );

  cfg_sup_stretch #(.LEN(STRETCH_CYC)) u_str (
    .clk_i, .rst_ni, .act_i(rx_act_i | tx_act_i), .led_o(act_led)
  );

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_SAMPLE: if (tmr_q == TW'(SAMPLE_CYC - 1))
                   nxt = (btn_q && !restart_q) ? ST_UPD : ST_PCHK;
      ST_PCHK:   if (prog_s) nxt = ST_WDONE;
                 else if (tmr_q == TW'(PCHK_CYC - 1)) nxt = ST_PFAULT;
      ST_WDONE:  if (done_s) nxt = ST_RUN;
                 else if (tmr_q == TW'(DONE_TO_CYC - 1)) nxt = ST_DFAULT;
      ST_DFAULT: if (tmr_q == TW'(FAULT_CYC - 1)) nxt = ST_UPD;
      ST_UPD:    if (upd_reset_i) nxt = ST_SAMPLE;
                 else if (upd_exit_i) nxt = ST_BOOT;
      ST_PFAULT, ST_RUN, ST_BOOT: nxt = state_q;
      default:   nxt = ST_SAMPLE;
    endcase
  end

  assign chg = (nxt != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_SAMPLE;
      tmr_q     <= '0;
      restart_q <= 1'b0;
    end else begin
      state_q <= nxt;
      if (chg)                    tmr_q <= '0;
      else if (tmr_q != TW'(TMAX)) tmr_q <= tmr_q + 1'b1;
      if (state_q == ST_UPD && upd_reset_i)        restart_q <= 1'b1;
      else if (state_q == ST_SAMPLE && chg)        restart_q <= 1'b0;
    end
  end

  always_comb begin
    led_o  = 1'b0;
    mode_o = MODE_START;
    unique case (state_q)
      ST_PFAULT: led_o = slow_ph;
      ST_WDONE:  led_o = slow_ph & fast_ph;
      ST_DFAULT: led_o = fast_ph;
      ST_RUN:    begin led_o = act_led; mode_o = MODE_RUN;    end
      ST_UPD:    begin led_o = 1'b1;    mode_o = MODE_UPDATE; end
      ST_BOOT:   begin led_o = 1'b1;    mode_o = MODE_BOOT;   end
      default:   led_o = 1'b0;
    endcase
  end

  assign prog_b_low_o = (state_q == ST_SAMPLE);
  assign bridge_en_o  = (state_q == ST_RUN);
endmodule

// File: rtl/cfg_supervisor_chk.sv
module cfg_supervisor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       done_i,
  input logic       upd_reset_i,
  input logic       upd_exit_i,
  input logic       prog_b_low_o,
  input logic       bridge_en_o,
  input logic       led_o,
  input logic [1:0] mode_o
);
  assert_sample_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_b_low_o |-> (!bridge_en_o && mode_o == 2'd0 && !led_o));

  assert_update_led_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2) |-> led_o);

  assert_run_after_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bridge_en_o) |-> $past(done_i, 3));

  assert_bridge_only_run_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bridge_en_o |-> (mode_o == 2'd1));

  assert_boot_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd3) |=> (mode_o == 2'd3 && led_o));

  assert_run_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1 && (upd_reset_i || upd_exit_i)) |=> (mode_o == 2'd1));
endmodule

bind cfg_supervisor cfg_supervisor_chk u_chk (
  .clk_i, .rst_ni, .done_i, .upd_reset_i, .upd_exit_i,
  .prog_b_low_o, .bridge_en_o, .led_o, .mode_o
);

// File: tb/cfg_supervisor_tb.sv
module cfg_supervisor_tb;
  localparam int DEB = 8, SAMP = 12, PCHK = 16, DTO = 200, FLT = 100;
  localparam int SLOW = 20, FAST = 5, STR = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic btn = 1'b0, pull_ok = 1'b1, done = 1'b0;
  logic rx = 1'b0, tx = 1'b0, ureset = 1'b0, uexit = 1'b0;
  logic prog_b, prog_low, bridge, led;
  logic [1:0] mode;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  assign prog_b = prog_low ? 1'b0 : pull_ok;

  cfg_supervisor #(
    .DEB_CYC(DEB), .SAMPLE_CYC(SAMP), .PCHK_CYC(PCHK), .DONE_TO_CYC(DTO),
    .FAULT_CYC(FLT), .SLOW_HALF(SLOW), .FAST_HALF(FAST), .STRETCH_CYC(STR)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .upd_btn_i(btn), .prog_b_i(prog_b), .done_i(done),
    .rx_act_i(rx), .tx_act_i(tx), .upd_reset_i(ureset), .upd_exit_i(uexit),
    .prog_b_low_o(prog_low), .bridge_en_o(bridge), .led_o(led), .mode_o(mode)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
  endtask

  task automatic half_len(output int n);
    logic v;
    int guard;
    v = led; guard = 0;
    while (led == v && guard < 1000) begin cyc(1); guard++; end
    v = led; n = 0;
    while (led == v && n < 1000) begin cyc(1); n++; end
  endtask

  task automatic pulse_count(input int gap, output int n);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      tx = (i == 0) || (gap != 0 && i == gap);
      cyc(1);
      if (led) n++;
    end
    tx = 1'b0;
  endtask

  initial begin
    cyc(100000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    // Scenario A: pull-up missing
    pull_ok = 1'b0; btn = 1'b0;
    do_reset();
    cyc(2);
    chk(prog_low == 1'b1, "R1", "prog_b_low", prog_low, 1);
    chk(mode == 2'd0, "R1", "mode", mode, 0);
    chk(bridge == 1'b0 && led == 1'b0, "R1", "bridge|led", {bridge, led}, 0);
    cyc(40);
    half_len(n); chk(n == SLOW, "R3", "slow half", n, SLOW);
    half_len(n); chk(n == SLOW, "R3", "slow half", n, SLOW);
    chk(mode == 2'd0 && prog_low == 1'b0, "R3", "mode", mode, 0);

    // Scenario B: button held through reset
    pull_ok = 1'b1; btn = 1'b1;
    do_reset();
    cyc(30);
    chk(mode == 2'd2, "R2", "mode", mode, 2);
    chk(led == 1'b1 && bridge == 1'b0, "R2", "led", led, 1);
    uexit = 1'b1; cyc(1); uexit = 1'b0;
    cyc(1);
    chk(mode == 2'd3, "R9", "mode", mode, 3);
    chk(led == 1'b1, "R9", "led", led, 1);
    ureset = 1'b1; cyc(1); ureset = 1'b0;
    cyc(5);
    chk(mode == 2'd3, "R10", "boot ignores reset cmd", mode, 3);

    // Scenario C: short button glitch, normal run path
    btn = 1'b0; done = 1'b0;
    do_reset();
    btn = 1'b1; cyc(4); btn = 1'b0;
    cyc(40);
    chk(mode == 2'd0, "R11", "short press ignored", mode, 0);
    n = 0;
    for (int i = 0; i < 2 * SLOW; i++) begin cyc(1); if (led) n++; end
    chk(n == SLOW / 2, "R4", "wait pattern highs", n, SLOW / 2);
    done = 1'b1;
    cyc(6);
    chk(mode == 2'd1, "R6", "mode", mode, 1);
    chk(bridge == 1'b1, "R6", "bridge", bridge, 1);
    chk(led == 1'b0, "R6", "led idle", led, 0);
    pulse_count(0, n); chk(n == STR, "R7", "single stretch", n, STR);
    pulse_count(5, n); chk(n == STR + 5, "R7", "retrigger stretch", n, STR + 5);
    rx = 1'b1; cyc(1); rx = 1'b0;
    chk(led == 1'b1, "R7", "rx activity", led, 1);
    cyc(STR + 2);
    ureset = 1'b1; uexit = 1'b1; cyc(1); ureset = 1'b0; uexit = 1'b0;
    cyc(5);
    chk(mode == 2'd1 && bridge == 1'b1, "R10", "run ignores cmds", mode, 1);

    // Scenario D: DONE timeout, fallback, restart command
    done = 1'b0; btn = 1'b0;
    do_reset();
    cyc(205);
    chk(mode == 2'd0, "R5", "still waiting", mode, 0);
    cyc(20);
    half_len(n); chk(n == FAST, "R5", "fast half", n, FAST);
    half_len(n); chk(n == FAST, "R5", "fast half", n, FAST);
    cyc(100);
    chk(mode == 2'd2, "R5", "fallback mode", mode, 2);
    chk(led == 1'b1, "R5", "fallback led", led, 1);
    btn = 1'b1;
    cyc(20);
    ureset = 1'b1; cyc(1); ureset = 1'b0;
    chk(prog_low == 1'b1, "R8", "restart drives low", prog_low, 1);
    chk(mode == 2'd0, "R8", "restart mode", mode, 0);
    cyc(20);
    chk(mode == 2'd0, "R8", "button ignored", mode, 0);
    done = 1'b1;
    cyc(6);
    chk(mode == 2'd1, "R8", "run after restart", mode, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule